// File: doc/BRIEF.md
# PHY Interrupt Control/Status Register

This block is a 16-bit management register inside an Ethernet transceiver. It holds eight sticky event flags in its low byte and eight enable bits in its high byte. When a flag is set and its enable is set, the interrupt pin goes to its active level. A separate bit from another register sets which level counts as active.

Software reaches the block through a register access port that is already decoded. The port has a read strobe, a write strobe, write data and read data. Reading the register returns all sixteen bits and clears the eight flags. Writing it loads only the enable byte. The event inputs come from the link, receive and auto-negotiation logic. Most of them set their flag whenever the indicator is high. The receive-error flag sets only on a rising edge of its input. The link-change flag sets whenever the link-OK input changes value, in either direction.

Top module: `phy_irq_reg`

## Requirements
- R1: After reset all sixteen register bits read as 0, and the interrupt pin is at its inactive level.
- R2: A write loads wr_data[15:8] into the enable byte, which reads back from the next cycle. The values written to wr_data[7:0] have no effect on the flags.
- R3: Each of these flags sets in the cycle after its indicator is high: jabber sets bit 7, page received sets bit 5, parallel-detect fault sets bit 4, link-partner acknowledge sets bit 3, remote fault sets bit 1, and auto-negotiation complete sets bit 0.
- R4: Bit 6 sets only when rx_err goes from 0 to 1. Holding rx_err high does not set bit 6 again after it has been cleared.
- R5: Bit 2 sets when link_ok changes from 0 to 1 and when it changes from 1 to 0. The previous link value held inside the block resets to 0.
- R6: During a cycle with rd_stb high, rd_data shows the flags as they stood before the read. From the next cycle, the flags read as 0.
- R7: If an event arrives in the same cycle as a clearing read, its flag is set after that read.
- R8: A set flag stays set until a read clears it, even after its event indicator has dropped.
- R9: The interrupt is active exactly when at least one flag and its enable bit (8 positions higher) are both 1. A flag whose enable bit is 0 does not activate the interrupt.
- R10: When irq_pol is 1, irq_pin is high while the interrupt is active. When irq_pol is 0, irq_pin is low while the interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | Register read strobe; clears the flags |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; only bits 15:8 are used |
| rd_data | output | 16 | Enable byte in bits 15:8, flags in bits 7:0 |
| irq_pol | input | 1 | 1 = active-high pin, 0 = active-low pin |
| ev_jabber | input | 1 | Jabber indicator |
| rx_err | input | 1 | Receive error signal; edge detected |
| ev_page | input | 1 | New page received indicator |
| ev_pdfault | input | 1 | Parallel-detect fault indicator |
| ev_lpack | input | 1 | Link-partner acknowledge seen in received bursts |
| link_ok | input | 1 | Link status level; any change is detected |
| ev_rfault | input | 1 | Remote fault indicator |
| ev_ancomp | input | 1 | Auto-negotiation complete indicator |
| irq_pin | output | 1 | Interrupt pin level |

## Verification
Flag, enable and edge-history state all update at the clock edge that samples the stimulus. rd_data and irq_pin are combinational from that state, so every result is due one cycle after its stimulus. The exception is the read strobe's own rd_data value, which is due in the same cycle, before the clearing edge. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge and compares both outputs at the next falling edge. Directed checks sample at that same point, either just before or just after the edge that matters.

// File: rtl/phy_irq_reg.sv
module phy_irq_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  input  logic        irq_pol,
  input  logic        ev_jabber,
  input  logic        rx_err,
  input  logic        ev_page,
  input  logic        ev_pdfault,
  input  logic        ev_lpack,
  input  logic        link_ok,
  input  logic        ev_rfault,
  input  logic        ev_ancomp,
  output logic        irq_pin
);
  localparam int NEV = 8;

  logic [NEV-1:0] en_q, flag_q, hit;
  logic           rxe_q, lnk_q, rx_rise, lnk_chg, active;

  assign rx_rise = rx_err & ~rxe_q;
  assign lnk_chg = link_ok ^ lnk_q;
  assign hit     = {ev_jabber, rx_rise, ev_page, ev_pdfault,
                    ev_lpack, lnk_chg, ev_rfault, ev_ancomp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      flag_q <= '0;
      rxe_q  <= 1'b0;
      lnk_q  <= 1'b0;
    end else begin
      rxe_q  <= rx_err;
      lnk_q  <= link_ok;
      flag_q <= (rd_stb ? '0 : flag_q) | hit;
      if (wr_stb) en_q <= wr_data[15:8];
    end
  end

  assign rd_data = {en_q, flag_q};
  assign active  = |(en_q & flag_q);
  assign irq_pin = irq_pol ? active : ~active;

  // R2
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> rd_data[15:8] == $past(wr_data[15:8]));
  // R2
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(rd_data[15:8]));
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && flag_q != '0) |=> (flag_q & $past(flag_q)) == $past(flag_q));
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && hit == '0) |=> flag_q == '0);
  // R7
  event_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (flag_q & $past(hit)) == $past(hit));
endmodule

// File: tb/phy_irq_reg_tb.sv
`timescale 1ns/1ps
module phy_irq_reg_tb;
  logic clk = 0, rst_n = 0;
  logic rd_stb = 0, wr_stb = 0, irq_pol = 1;
  logic [15:0] wr_data = 0;
  logic ev_jabber = 0, rx_err = 0, ev_page = 0, ev_pdfault = 0;
  logic ev_lpack = 0, link_ok = 0, ev_rfault = 0, ev_ancomp = 0;
  wire [15:0] rd_data;
  wire irq_pin;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_irq_reg u_dut (.clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_data(rd_data), .irq_pol(irq_pol), .ev_jabber(ev_jabber),
    .rx_err(rx_err), .ev_page(ev_page), .ev_pdfault(ev_pdfault), .ev_lpack(ev_lpack),
    .link_ok(link_ok), .ev_rfault(ev_rfault), .ev_ancomp(ev_ancomp), .irq_pin(irq_pin));

  // behavioural reference
  bit [7:0] m_en, m_fl;
  bit m_rx, m_lk;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_fl = 0; m_rx = 0; m_lk = 0;
    end else begin
      if (rd_stb) m_fl = 0;
      if (ev_jabber) m_fl[7] = 1;
      if (rx_err && !m_rx) m_fl[6] = 1;
      if (ev_page) m_fl[5] = 1;
      if (ev_pdfault) m_fl[4] = 1;
      if (ev_lpack) m_fl[3] = 1;
      if (link_ok != m_lk) m_fl[2] = 1;
      if (ev_rfault) m_fl[1] = 1;
      if (ev_ancomp) m_fl[0] = 1;
      if (wr_stb) m_en = wr_data[15:8];
      m_rx = rx_err; m_lk = link_ok;
    end
  end

  function automatic bit m_pin();
    bit act = (m_en & m_fl) != 0;
    return irq_pol ? act : !act;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock, then compare against the model away from the edge
  task automatic tick();
    @(posedge clk); @(negedge clk);
    chk("R6 rd_data vs model", rd_data, {m_en, m_fl});
    chk("R9/R10 irq_pin vs model", irq_pin, m_pin());
  endtask

  task automatic clear_events();
    ev_jabber = 0; ev_page = 0; ev_pdfault = 0; ev_lpack = 0;
    ev_rfault = 0; ev_ancomp = 0; rd_stb = 0; wr_stb = 0;
  endtask

  task automatic do_read();
    rd_stb = 1; tick(); rd_stb = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset rd_data", rd_data, 0);
    chk("R1 reset pin inactive", irq_pin, 0);

    // R2 write loads enables only
    wr_stb = 1; wr_data = 16'hFFFF; tick(); wr_stb = 0;
    chk("R2 enable byte loaded, low byte ignored", rd_data, 16'hFF00);

    // R3 jabber + R10 active-high
    ev_jabber = 1; tick(); ev_jabber = 0;
    chk("R3 jabber bit7", rd_data[7:0], 8'h80);
    chk("R10 pin high when active, pol=1", irq_pin, 1);
    // R8 sticky
    tick(); tick(); tick();
    chk("R8 flag sticky", rd_data[7:0], 8'h80);

    // R6 read shows old value, then clears
    rd_stb = 1;
    #1 chk("R6 read data before clear", rd_data[7:0], 8'h80);
    tick(); rd_stb = 0;
    chk("R6 flags cleared after read", rd_data[7:0], 0);
    chk("R1 pin inactive again", irq_pin, 0);

    // R3 remaining level events
    ev_page = 1; ev_pdfault = 1; tick(); clear_events();
    chk("R3 page bit5 / pdfault bit4", rd_data[7:0], 8'h30);
    do_read();
    ev_lpack = 1; ev_rfault = 1; ev_ancomp = 1; tick(); clear_events();
    chk("R3 lpack bit3 / rfault bit1 / ancomp bit0", rd_data[7:0], 8'h0B);
    do_read();

    // R4 receive error edge only
    rx_err = 1; tick();
    chk("R4 rx_err rise sets bit6", rd_data[7:0], 8'h40);
    do_read();
    tick(); tick();
    chk("R4 held rx_err does not reset flag", rd_data[7:0], 0);
    rx_err = 0; tick(); rx_err = 1; tick();
    chk("R4 second rise sets bit6", rd_data[7:0], 8'h40);
    rx_err = 0; do_read();

    // R5 link changes both ways
    link_ok = 1; tick();
    chk("R5 link up sets bit2", rd_data[7:0], 8'h04);
    do_read(); tick();
    chk("R5 steady link no flag", rd_data[7:0], 0);
    link_ok = 0; tick();
    chk("R5 link down sets bit2", rd_data[7:0], 8'h04);
    do_read();

    // R7 event coincident with read
    ev_jabber = 1; tick(); ev_jabber = 0;
    rd_stb = 1; ev_ancomp = 1; tick(); clear_events();
    chk("R7 event during read survives", rd_data[7:0], 8'h01);
    do_read();

    // R9 disabled flag gives no interrupt
    wr_stb = 1; wr_data = 16'h7F00; tick(); wr_stb = 0;
    ev_jabber = 1; tick(); ev_jabber = 0;
    chk("R9 masked flag set", rd_data[7:0], 8'h80);
    chk("R9 masked flag no irq", irq_pin, 0);
    ev_rfault = 1; tick(); ev_rfault = 0;
    chk("R9 enabled flag irq", irq_pin, 1);

    // R10 active-low
    irq_pol = 0; #1;
    chk("R10 pin low when active, pol=0", irq_pin, 0);
    do_read();
    chk("R10 pin high when idle, pol=0", irq_pin, 1);

    // random traffic against the model
    for (int i = 0; i < 400; i++) begin
      rd_stb = ($urandom % 5) == 0;
      wr_stb = ($urandom % 9) == 0;
      wr_data = 16'($urandom);
      irq_pol = ($urandom % 7) != 0;
      ev_jabber = ($urandom % 11) == 0;
      rx_err = ($urandom % 3) == 0;
      ev_page = ($urandom % 13) == 0;
      ev_pdfault = ($urandom % 17) == 0;
      ev_lpack = ($urandom % 13) == 0;
      link_ok = ($urandom % 6) != 0 ? link_ok : !link_ok;
      ev_rfault = ($urandom % 19) == 0;
      ev_ancomp = ($urandom % 23) == 0;
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule